// File: doc/BRIEF.md
# Extended-Precision Exponent Scaling Unit

The unit multiplies an 80-bit extended-precision value A by a power of two. The power comes from a second extended value B, truncated toward zero to an integer. A word holds a sign in bit 79, a 15-bit exponent biased by 0x3FFF in bits 78:64, and a 64-bit significand in bits 63:0 whose bit 63 is an explicit integer bit. The unit adds the integer part of B to the exponent of A, or subtracts it when B is negative. The significand of A is carried through without rounding, except where the result saturates.

A request is presented with a one-cycle strobe. Exactly one clock later the result and its flags appear together with an output strobe, and they hold until the next request. Both NaN and infinity use the all-ones exponent. An encoding with that exponent is a NaN when significand bits 62:0 are not all zero, and an infinity when they are all zero, whatever bit 63 holds. A NaN is quiet when significand bit 62 is set and signaling when it is clear. The unit resolves NaNs, infinities, zeros and subnormal A operands before it scales. It saturates results that leave the exponent range to a signed infinity or a signed zero, and reports an invalid, overflow or underflow flag.

Top module: `xp_exp_scaler`

## Requirements
- R1: If either operand is a NaN, the result is A when A is a NaN and B otherwise, with significand bit 62 forced to 1. The invalid flag is raised exactly when one of the NaN operands has bit 62 clear.
- R2: If B is an infinity and neither operand is a NaN, the invalid flag is raised and the result is the default NaN: sign 0, exponent 0x7FFF, significand all ones.
- R3: If A is an infinity and B is finite, the result is sign of A, exponent 0x7FFF, significand zero, and no flag is raised.
- R4: If A has exponent 0 and significand 0, and B is finite, the result is a zero carrying A's sign.
- R5: If B is finite with biased exponent below 0x3FFF, and A is neither a NaN, an infinity nor a zero, the result equals A bit for bit. This holds even when A is subnormal.
- R6: An A with exponent 0 and a nonzero significand is first normalised. Its significand is shifted left until bit 63 is set, and its exponent becomes 1 minus the shift count.
- R7: For B exponents from 0x3FFF to 0x400F, the integer is the significand of B shifted right by (0x403E − exponent of B). It is added to the exponent of A, or subtracted when B's sign is 1. The result keeps A's sign and its normalised significand.
- R8: For a finite B with exponent above 0x400F, the result is an overflow infinity when B is positive and an underflow zero when B is negative.
- R9: A scaled exponent of 0x7FFF or more gives sign of A, exponent 0x7FFF and significand zero, with the overflow flag set. At most one of the three flags is ever set.
- R10: A scaled exponent of zero or below gives a zero carrying A's sign, with the underflow flag set.
- R11: The output strobe is high in exactly the cycle after each input strobe. Result and flags change only when a request is captured.
- R12: After reset the output strobe, the result and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request strobe for opA and opB |
| opA | input | 80 | Value to be scaled |
| opB | input | 80 | Scale operand; its integer part is used |
| outValid | output | 1 | Result strobe, one cycle after inValid |
| result | output | 80 | Scaled value |
| flagInvalid | output | 1 | Invalid operation (signaling NaN or infinite B) |
| flagOverflow | output | 1 | Result saturated to infinity |
| flagUnderflow | output | 1 | Result saturated to zero |

## Verification
All state in this unit sits in one register stage. A wrong decision in the special-case priority, or in the exponent arithmetic, shows up in the result word on the very next output strobe: a wrong exponent, a lost sign, a NaN that was not made quiet, or a flag that should not be set. A wrong shift count shows up as an exponent that is off by a power-of-two ratio, so the checks pick B values whose integer bits sit at both ends of the shift window. A broken capture enable shows up as a result that changes between strobes, or as a strobe missing from the cycle after a request.

// File: rtl/xps_pkg.sv
package xps_pkg;
  // Operand format
  parameter int EXP_W = 15;
  parameter int SIG_W = 64;
  // Widest integer taken from B before the exponent is forced to saturate
  parameter int INT_BITS = 17;
  // Distance pushed beyond the exponent range for out-of-window B
  parameter int SAT_MARGIN = 24577;

  localparam int WORD_W = 1 + EXP_W + SIG_W;
  localparam int EW     = EXP_W + 5;           // signed working exponent
  localparam int SH_W   = $clog2(SIG_W);
  localparam int LZ_W   = $clog2(SIG_W) + 1;

  localparam logic [EXP_W-1:0] EXP_TOP  = '1;
  localparam logic [EXP_W-1:0] BIAS     = EXP_W'((1 << (EXP_W - 1)) - 1);
  localparam logic [EXP_W-1:0] SAT_EXP  = EXP_W'(int'(BIAS) + INT_BITS - 1);
  localparam logic [EXP_W-1:0] SH_BASE  = EXP_W'(int'(BIAS) + SIG_W - 1);

  typedef struct packed {
    logic load;
  } xpsStrobeT;
endpackage

// File: rtl/xps_lzc.sv
module xps_lzc #(
  parameter int W  = 64,
  parameter int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  val,
  output logic [CW-1:0] count
);
  // Highest set bit wins because later iterations overwrite earlier ones
  always_comb begin
    count = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (val[i]) count = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/xps_ctrl.sv
module xps_ctrl
  import xps_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output xpsStrobeT strobe,
  output logic      outValid
);
  assign strobe.load = inValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);  // R11
  AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);  // R11
endmodule

// File: rtl/xps_datapath.sv
module xps_datapath
  import xps_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  xpsStrobeT         strobe,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic [WORD_W-1:0] result,
  output logic              flagInv,
  output logic              flagOvf,
  output logic              flagUnf
);
  localparam logic signed [EW-1:0] TOP_S   = EW'(int'(EXP_TOP));
  localparam logic signed [EW-1:0] FORCE_HI = EW'(int'(EXP_TOP) + SAT_MARGIN);
  localparam logic signed [EW-1:0] FORCE_LO = EW'(-SAT_MARGIN);
  localparam logic [SIG_W-1:0]     QUIET_BIT = SIG_W'(1) << (SIG_W - 2);

  logic             aSign, bSign;
  logic [EXP_W-1:0] aExp, bExp;
  logic [SIG_W-1:0] aSig, bSig;
  logic             aNaN, bNaN, aInf, bInf, aZero, aSub;
  logic [LZ_W-1:0]  lzCount;
  logic [SIG_W-1:0] normSig;
  logic signed [EW-1:0] normExp, intMag, scaledExp;
  logic [SH_W-1:0]  shAmt;

  logic [WORD_W-1:0] nxtResult;
  logic              nxtInv, nxtOvf, nxtUnf;

  assign {aSign, aExp, aSig} = opA;
  assign {bSign, bExp, bSig} = opB;

  assign aNaN  = (aExp == EXP_TOP) && (|aSig[SIG_W-2:0]);
  assign bNaN  = (bExp == EXP_TOP) && (|bSig[SIG_W-2:0]);
  assign aInf  = (aExp == EXP_TOP) && !(|aSig[SIG_W-2:0]);
  assign bInf  = (bExp == EXP_TOP) && !(|bSig[SIG_W-2:0]);
  assign aZero = (aExp == '0) && (aSig == '0);
  assign aSub  = (aExp == '0) && (aSig != '0);

  xps_lzc #(.W(SIG_W), .CW(LZ_W)) i_lzc (
    .val   (aSig),
    .count (lzCount)
  );

  // Normalisation of a subnormal A
  always_comb begin
    if (aSub) begin
      normSig = aSig << lzCount;
      normExp = EW'(1) - $signed(EW'(lzCount));
    end else begin
      normSig = aSig;
      normExp = $signed(EW'(aExp));
    end
  end

  // Integer part of B by right shift inside the window
  assign shAmt  = SH_W'(SH_BASE - bExp);
  assign intMag = $signed(EW'(bSig >> shAmt));

  always_comb begin
    if (bExp > SAT_EXP)  scaledExp = bSign ? FORCE_LO : FORCE_HI;
    else if (bSign)      scaledExp = normExp - intMag;
    else                 scaledExp = normExp + intMag;
  end

  // Priority resolution of special operands, then range saturation
  always_comb begin
    nxtResult = '0;
    nxtInv    = 1'b0;
    nxtOvf    = 1'b0;
    nxtUnf    = 1'b0;
    if (aNaN || bNaN) begin
      nxtResult = (aNaN ? opA : opB) | {{(1 + EXP_W){1'b0}}, QUIET_BIT};
      nxtInv    = (aNaN && !aSig[SIG_W-2]) || (bNaN && !bSig[SIG_W-2]);
    end else if (bInf) begin
      nxtResult = {1'b0, EXP_TOP, {SIG_W{1'b1}}};
      nxtInv    = 1'b1;
    end else if (aInf) begin
      nxtResult = {aSign, EXP_TOP, {SIG_W{1'b0}}};
    end else if (aZero) begin
      nxtResult = {aSign, {(EXP_W + SIG_W){1'b0}}};
    end else if (bExp < BIAS) begin
      nxtResult = opA;
    end else if (scaledExp >= TOP_S) begin
      nxtResult = {aSign, EXP_TOP, {SIG_W{1'b0}}};
      nxtOvf    = 1'b1;
    end else if (scaledExp <= 0) begin
      nxtResult = {aSign, {(EXP_W + SIG_W){1'b0}}};
      nxtUnf    = 1'b1;
    end else begin
      nxtResult = {aSign, scaledExp[EXP_W-1:0], normSig};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result  <= '0;
      flagInv <= 1'b0;
      flagOvf <= 1'b0;
      flagUnf <= 1'b0;
    end else if (strobe.load) begin
      result  <= nxtResult;
      flagInv <= nxtInv;
      flagOvf <= nxtOvf;
      flagUnf <= nxtUnf;
    end
  end

  AST_OVF_GIVES_INF: assert property (@(posedge clk) disable iff (!rstN)
    flagOvf |-> (result[WORD_W-2 -: EXP_W] == EXP_TOP) && (result[SIG_W-1:0] == '0));  // R9
  AST_UNF_GIVES_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    flagUnf |-> (result[WORD_W-2:0] == '0));  // R10
  AST_INV_GIVES_QNAN: assert property (@(posedge clk) disable iff (!rstN)
    flagInv |-> (result[WORD_W-2 -: EXP_W] == EXP_TOP) && result[SIG_W-2]);  // R1
  AST_SINGLE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    $countones({flagInv, flagOvf, flagUnf}) <= 1);  // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(result) && $stable({flagInv, flagOvf, flagUnf}));  // R11
  AST_SMALL_B_PASS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load && !aNaN && !bNaN && !bInf && !aInf && !aZero && (bExp < BIAS)
      |=> (result == $past(opA)));  // R5
endmodule

// File: rtl/xp_exp_scaler.sv
module xp_exp_scaler
  import xps_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic              outValid,
  output logic [WORD_W-1:0] result,
  output logic              flagInvalid,
  output logic              flagOverflow,
  output logic              flagUnderflow
);
  xpsStrobeT strobe;

  xps_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  xps_datapath i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .opA     (opA),
    .opB     (opB),
    .result  (result),
    .flagInv (flagInvalid),
    .flagOvf (flagOverflow),
    .flagUnf (flagUnderflow)
  );
endmodule

// File: tb/test_xp_exp_scaler.sv
module test_xp_exp_scaler;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [79:0] opA = '0;
  logic [79:0] opB = '0;
  logic        outValid;
  logic [79:0] result;
  logic        flagInvalid, flagOverflow, flagUnderflow;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  logic [82:0] expQ[$];
  string       tagQ[$];
  logic [82:0] lastExp = '0;

  always #10 clk = ~clk;  // 50 MHz

  xp_exp_scaler i_xp_exp_scaler (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .outValid(outValid), .result(result), .flagInvalid(flagInvalid),
    .flagOverflow(flagOverflow), .flagUnderflow(flagUnderflow)
  );

  function automatic logic [79:0] fp(logic s, logic [14:0] e, logic [63:0] m);
    return {s, e, m};
  endfunction

  task automatic check(bit ok, string tag, logic [82:0] act, logic [82:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: applies one request and queues its expected outcome
  task automatic send(logic [79:0] a, logic [79:0] b, logic [79:0] r,
                      logic inv, logic ovf, logic unf, string tag);
    @(negedge clk);
    opA = a;
    opB = b;
    inValid = 1'b1;
    expQ.push_back({r, inv, ovf, unf});
    tagQ.push_back(tag);
    lastExp = {r, inv, ovf, unf};
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  // Monitor: compares each output strobe with the oldest queued item
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && outValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R11 unexpected strobe", {result, flagInvalid, flagOverflow, flagUnderflow}, '0);
        end else begin
          logic [82:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check({result, flagInvalid, flagOverflow, flagUnderflow} === e, t,
                {result, flagInvalid, flagOverflow, flagUnderflow}, e);
        end
      end
    end
  end

  localparam logic [63:0] M1 = 64'h8000_0000_0000_0000;

  initial begin
    // R12 reset state
    repeat (3) @(negedge clk);
    check({outValid, result, flagInvalid, flagOverflow, flagUnderflow} === '0, "R12 reset",
          {result, flagInvalid, flagOverflow, flagUnderflow}, '0);
    rstN = 1'b1;
    idle(2);

    // R7 plain scaling, truncation, both signs
    send(fp(0,15'h3FFF,64'hC000_0000_0000_0000), fp(0,15'h4000,64'hC000_0000_0000_0000),
         fp(0,15'h4002,64'hC000_0000_0000_0000), 0,0,0, "R7 1.5 by 3");
    send(fp(1,15'h4005,64'h9234_5678_9ABC_DEF0), fp(1,15'h4001,64'hA000_0000_0000_0000),
         fp(1,15'h4000,64'h9234_5678_9ABC_DEF0), 0,0,0, "R7 by -5");
    send(fp(0,15'h1234,64'h8000_0000_0000_0001), fp(0,15'h4000,64'hB999_9999_9999_9999),
         fp(0,15'h1236,64'h8000_0000_0000_0001), 0,0,0, "R7 truncate 2.9");
    send(fp(0,15'h7000,64'hA5A5_A5A5_A5A5_A5A5), fp(1,15'h400D,M1),
         fp(0,15'h3000,64'hA5A5_A5A5_A5A5_A5A5), 0,0,0, "R7 by -16384");
    // R8 out-of-window B
    send(fp(0,15'h0001,M1), fp(0,15'h4010,M1), fp(0,15'h7FFF,64'h0), 0,1,0, "R8 huge positive");
    send(fp(1,15'h7FFE,64'hFFFF_FFFF_FFFF_FFFF), fp(1,15'h4010,M1), fp(1,15'h0,64'h0), 0,0,1, "R8 huge negative");
    // R9 overflow edge
    send(fp(0,15'h7FFE,M1), fp(0,15'h3FFF,M1), fp(0,15'h7FFF,64'h0), 0,1,0, "R9 reach 0x7FFF");
    send(fp(1,15'h7FFD,64'h8123_0000_0000_0000), fp(0,15'h3FFF,M1),
         fp(1,15'h7FFE,64'h8123_0000_0000_0000), 0,0,0, "R9 largest finite");
    // R10 underflow edge
    send(fp(1,15'h0002,64'hC000_0000_0000_0000), fp(1,15'h4000,M1), fp(1,15'h0,64'h0), 0,0,1, "R10 reach zero");
    send(fp(0,15'h0002,64'hC000_0000_0000_0000), fp(1,15'h3FFF,M1),
         fp(0,15'h0001,64'hC000_0000_0000_0000), 0,0,0, "R10 smallest normal");
    // R6 subnormal A
    send(fp(0,15'h0,64'h0000_0000_0000_0100), fp(0,15'h4005,64'hC800_0000_0000_0000),
         fp(0,15'h002E,M1), 0,0,0, "R6 subnormal by 100");
    send(fp(0,15'h0,64'h0000_0000_0000_0100), fp(0,15'h3FFF,M1), fp(0,15'h0,64'h0), 0,0,1, "R6 subnormal underflow");
    // R5 small B leaves A untouched
    send(fp(1,15'h0,64'h0000_0000_0000_0100), fp(0,15'h3FFE,M1),
         fp(1,15'h0,64'h0000_0000_0000_0100), 0,0,0, "R5 subnormal kept");
    send(fp(0,15'h4444,64'h9999_0000_0000_0001), fp(1,15'h3FFE,64'hFFFF_FFFF_FFFF_FFFF),
         fp(0,15'h4444,64'h9999_0000_0000_0001), 0,0,0, "R5 negative fraction B");
    // R4 zero A
    send(fp(1,15'h0,64'h0), fp(0,15'h4000,64'hC000_0000_0000_0000), fp(1,15'h0,64'h0), 0,0,0, "R4 negative zero");
    // R3 infinite A
    send(fp(1,15'h7FFF,M1), fp(0,15'h4000,M1), fp(1,15'h7FFF,64'h0), 0,0,0, "R3 inf with integer bit");
    send(fp(0,15'h7FFF,64'h0), fp(1,15'h4000,64'hC000_0000_0000_0000), fp(0,15'h7FFF,64'h0), 0,0,0, "R3 inf without integer bit");
    // R2 infinite B
    send(fp(0,15'h3FFF,64'hC000_0000_0000_0000), fp(1,15'h7FFF,M1),
         fp(0,15'h7FFF,64'hFFFF_FFFF_FFFF_FFFF), 1,0,0, "R2 finite by inf");
    send(fp(1,15'h7FFF,M1), fp(0,15'h7FFF,64'h0),
         fp(0,15'h7FFF,64'hFFFF_FFFF_FFFF_FFFF), 1,0,0, "R2 inf by inf");
    // R1 NaN propagation
    send(fp(0,15'h7FFF,64'hC000_0000_0000_1234), fp(0,15'h4000,M1),
         fp(0,15'h7FFF,64'hC000_0000_0000_1234), 0,0,0, "R1 quiet A");
    send(fp(1,15'h7FFF,64'h8000_0000_0000_0005), fp(0,15'h3FFF,M1),
         fp(1,15'h7FFF,64'hC000_0000_0000_0005), 1,0,0, "R1 signaling A");
    send(fp(0,15'h3FFF,64'hC000_0000_0000_0000), fp(0,15'h7FFF,64'hC000_0000_0000_00AB),
         fp(0,15'h7FFF,64'hC000_0000_0000_00AB), 0,0,0, "R1 quiet B");
    send(fp(0,15'h7FFF,64'hC000_0000_0000_0077), fp(1,15'h7FFF,64'h8000_0000_0000_0099),
         fp(0,15'h7FFF,64'hC000_0000_0000_0077), 1,0,0, "R1 A wins, B signaling");

    // R11 idle gap: no strobe, outputs held
    idle(1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!outValid, "R11 strobe low when idle", {82'h0, outValid}, '0);
      check({result, flagInvalid, flagOverflow, flagUnderflow} === lastExp, "R11 held result",
            {result, flagInvalid, flagOverflow, flagUnderflow}, lastExp);
    end
    // R11 one isolated request after the gap
    send(fp(0,15'h3FFF,M1), fp(0,15'h4000,M1), fp(0,15'h4001,M1), 0,0,0, "R11 isolated request");
    idle(3);
    check(expQ.size() == 0, "R11 every request answered", 83'(expQ.size()), '0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL R11 watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule